// File: doc/BRIEF.md
# Cartridge Command and Transfer Controller

This block sits on the host side of a removable game-card bus. Software first fills an 8-byte command bank, writing one 16-bit halfword at a time. It then writes a control byte that holds a 3-bit size code and a start bit. The block looks at the first command byte. When that byte is the read opcode, it takes a 32-bit start address from the next four command bytes and begins to stream the block from a card memory port, one 32-bit word per fetch.

The host pulls the data through a data register. A read taken while the word-ready flag is set returns the buffered word. It also starts the next fetch, or ends the transfer when no bytes remain. Fetches use a request valid/ready handshake, and a single-cycle response strobe returns each word. The host can read the busy and word-ready flags, together with the current size code, from the status byte.

Top module: `cxc_top`

## Requirements
- R1: The command bank is written one halfword at a time. Halfword index k stores its low byte as command byte 2k and its high byte as command byte 2k+1.
- R2: When command byte 0 is 0xB7, a start write begins a read. Its start address is big-endian: command byte 1 is address bits 31:24 and command byte 4 is bits 7:0. The first memory request carries this address.
- R3: The size code sets the number of bytes moved:
  - Code n in 1..6 moves 256<<n bytes, which is 64<<n words.
  - Code 0 moves nothing and issues no memory request.
  - Code 7 moves exactly one 4-byte word.
- R4: Each fetch raises memReqValid while busy. The request address is held stable until memReqReady is seen. Successive requests advance the address by 4.
- R5: Word-ready rises only in the cycle after a memory response. The data register then shows the response word.
- R6: A data read while word-ready is set returns the buffered word. It clears word-ready on the next edge and starts the next fetch.
- R7: A data read while word-ready is clear has no effect: the buffered word is unchanged and no word is skipped.
- R8: When a step finds no bytes left, it clears the data register to zero and clears both word-ready and busy.
- R9: A start write whose opcode is not 0xB7 issues no memory request and leaves busy clear.
- R10: The status byte shows busy in bit 7, word-ready in bit 6, zeros in bits 5:3 and the size code in bits 2:0. A control write (start in bit 7, size code in bits 2:0) that has start clear only updates the size code.
- R11: Control writes made while busy are ignored, both the size code and a new start.
- R12: After reset the status byte, the data register and memReqValid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command halfword write strobe |
| cmdWrIdx | input | 2 | Halfword index within the command bank |
| cmdWrHalf | input | 16 | Halfword value (low byte = earlier command byte) |
| ctrlWrEn | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Bit 7 start, bits 2:0 size code |
| statusCtrl | output | 8 | Bit 7 busy, bit 6 word-ready, bits 2:0 size code |
| dataRdEn | input | 1 | Data register read strobe |
| dataRdData | output | 32 | Buffered word |
| memReqValid | output | 1 | Card memory fetch request |
| memReqReady | input | 1 | Card memory accepts the request |
| memReqAddr | output | 32 | Fetch byte address |
| memRspValid | input | 1 | Response word valid, one cycle |
| memRspData | input | 32 | Response word |

## Verification
Some internal faults show up on the memory port before they reach the data register. A wrong address or remaining-count register shows a request address that is off the expected +4 sequence, or a request count that does not match the size code. A miscounted remaining value shows, within one block, as a busy flag that drops early or late. A wrong ready or state bit shows within a cycle or two of a host read. The symptom is either a skipped or repeated word in the data stream, or a stale read that changes the buffer. The bench sweeps every size code with a stalling memory. It checks each returned word against an address-derived pattern, so a single misplaced step is caught at the next word.

// File: rtl/cxc_pkg.sv
package cxc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_REQ,
    ST_WAIT,
    ST_HOLD
  } cxcState_t;

  typedef struct packed {
    logic sizeWr;
    logic loadXfer;
    logic stepWord;
    logic clearBuf;
  } cxcStrobe_t;

endpackage

// File: rtl/cxc_datapath.sv
module cxc_datapath
  import cxc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CMD_BYTES  = 8,
  parameter int CODE_W     = 3,
  parameter int BASE_SHIFT = 8,
  parameter logic [7:0] READ_OP = 8'hB7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdWrEn,
  input  logic [$clog2(CMD_BYTES/2)-1:0] cmdWrIdx,
  input  logic [15:0]                   cmdWrHalf,
  input  logic [CODE_W-1:0]             ctrlWrSize,
  input  cxcStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             memRspData,
  output logic                          isReadOp,
  output logic                          remZero,
  output logic [ADDR_W-1:0]             curAddr,
  output logic [DATA_W-1:0]             bufWord,
  output logic [CODE_W-1:0]             sizeCode
);
  localparam int HALVES     = CMD_BYTES / 2;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BASE_LEN   = 1 << BASE_SHIFT;
  localparam int MAX_LEN    = BASE_LEN << ((1 << CODE_W) - 2);
  localparam int REM_W      = $clog2(MAX_LEN + 1);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [CMD_BYTES*8-1:0] cmdBank;
  logic [REM_W-1:0]       remBytes;
  logic [ADDR_W-1:0]      startAddr;

  function automatic logic [REM_W-1:0] lenOf(input logic [CODE_W-1:0] c);
    if (c == '0)      return '0;
    else if (c == '1) return REM_W'(WORD_BYTES);
    else              return REM_W'(BASE_LEN) << c;
  endfunction

  // command bank: halfword k holds bytes 2k (low) and 2k+1 (high)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBank <= '0;
    end else if (cmdWrEn) begin
      for (int h = 0; h < HALVES; h++) begin
        if (cmdWrIdx == h[$clog2(CMD_BYTES/2)-1:0]) cmdBank[h*16 +: 16] <= cmdWrHalf;
      end
    end
  end

  // big-endian start address from bytes 1..ADDR_BYTES
  always_comb begin
    startAddr = '0;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      startAddr[(ADDR_BYTES-1-b)*8 +: 8] = cmdBank[(b+1)*8 +: 8];
    end
  end

  assign isReadOp = (cmdBank[7:0] == READ_OP);
  assign remZero  = (remBytes == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeCode <= '0;
      remBytes <= '0;
      curAddr  <= '0;
      bufWord  <= '0;
    end else begin
      if (strobe.sizeWr) sizeCode <= ctrlWrSize;
      if (strobe.loadXfer) begin
        curAddr  <= startAddr;
        remBytes <= lenOf(ctrlWrSize);
      end
      if (strobe.stepWord) begin
        bufWord  <= memRspData;
        curAddr  <= curAddr + ADDR_W'(WORD_BYTES);
        remBytes <= remBytes - REM_W'(WORD_BYTES);
      end
      if (strobe.clearBuf) bufWord <= '0;
    end
  end

endmodule

// File: rtl/cxc_control.sv
module cxc_control
  import cxc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic       ctrlWrStart,
  input  logic       isReadOp,
  input  logic       remZero,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       dataRdEn,
  output cxcStrobe_t strobe,
  output logic       busy,
  output logic       wordReady,
  output logic       memReqValid
);
  cxcState_t state, stateNext;
  logic      readyNext;

  always_comb begin
    stateNext   = state;
    readyNext   = wordReady;
    strobe      = '0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ctrlWrEn) begin
          strobe.sizeWr = 1'b1;
          if (ctrlWrStart && isReadOp) begin
            strobe.loadXfer = 1'b1;
            stateNext       = ST_STEP;
          end
        end
      end
      ST_STEP: begin
        if (remZero) begin
          strobe.clearBuf = 1'b1;
          readyNext       = 1'b0;
          stateNext       = ST_IDLE;
        end else begin
          stateNext = ST_REQ;
        end
      end
      ST_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.stepWord = 1'b1;
          readyNext       = 1'b1;
          stateNext       = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (dataRdEn) begin
          readyNext = 1'b0;
          stateNext = ST_STEP;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordReady <= 1'b0;
    end else begin
      state     <= stateNext;
      wordReady <= readyNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/cxc_top.sv
module cxc_top
  import cxc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CMD_BYTES = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cmdWrEn,
  input  logic [$clog2(CMD_BYTES/2)-1:0] cmdWrIdx,
  input  logic [15:0]                    cmdWrHalf,
  input  logic                           ctrlWrEn,
  input  logic [7:0]                     ctrlWrData,
  output logic [7:0]                     statusCtrl,
  input  logic                           dataRdEn,
  output logic [DATA_W-1:0]              dataRdData,
  output logic                           memReqValid,
  input  logic                           memReqReady,
  output logic [ADDR_W-1:0]              memReqAddr,
  input  logic                           memRspValid,
  input  logic [DATA_W-1:0]              memRspData
);
  localparam int CODE_W    = 3;
  localparam int START_BIT = 7;

  cxcStrobe_t        strobe;
  logic              isReadOp;
  logic              remZero;
  logic              busy;
  logic              wordReady;
  logic [CODE_W-1:0] sizeCode;

  cxc_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrStart(ctrlWrData[START_BIT]),
    .isReadOp   (isReadOp),
    .remZero    (remZero),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .dataRdEn   (dataRdEn),
    .strobe     (strobe),
    .busy       (busy),
    .wordReady  (wordReady),
    .memReqValid(memReqValid)
  );

  cxc_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CMD_BYTES(CMD_BYTES),
    .CODE_W   (CODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrEn   (cmdWrEn),
    .cmdWrIdx  (cmdWrIdx),
    .cmdWrHalf (cmdWrHalf),
    .ctrlWrSize(ctrlWrData[CODE_W-1:0]),
    .strobe    (strobe),
    .memRspData(memRspData),
    .isReadOp  (isReadOp),
    .remZero   (remZero),
    .curAddr   (memReqAddr),
    .bufWord   (dataRdData),
    .sizeCode  (sizeCode)
  );

  assign statusCtrl = {busy, wordReady, {(8-2-CODE_W){1'b0}}, sizeCode};

endmodule

// File: rtl/cxc_checker.sv
module cxc_checker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CMD_BYTES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        statusCtrl,
  input logic              dataRdEn,
  input logic [DATA_W-1:0] dataRdData,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid
);
  a_r4_req_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> statusCtrl[7]);

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  a_r5_ready_after_rsp: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusCtrl[6]) |-> $past(memRspValid));

  a_r6_read_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    dataRdEn && statusCtrl[6] |=> !statusCtrl[6]);

  a_r7_stale_read: assert property (@(posedge clk) disable iff (!rstN)
    dataRdEn && !statusCtrl[6] && !memRspValid |=> $stable(dataRdData) || !statusCtrl[7]);

  a_r8_done_clean: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusCtrl[7]) |-> !statusCtrl[6] && dataRdData == '0);

  a_r10_ready_implies_busy: assert property (@(posedge clk) disable iff (!rstN)
    statusCtrl[6] |-> statusCtrl[7]);

endmodule

bind cxc_top cxc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_BYTES(CMD_BYTES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .statusCtrl (statusCtrl),
  .dataRdEn   (dataRdEn),
  .dataRdData (dataRdData),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .memRspValid(memRspValid)
);

// File: tb/cxc_top_test.sv
module cxc_top_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdWrEn;
  logic [1:0]  cmdWrIdx;
  logic [15:0] cmdWrHalf;
  logic        ctrlWrEn;
  logic [7:0]  ctrlWrData;
  logic [7:0]  statusCtrl;
  logic        dataRdEn;
  logic [31:0] dataRdData;
  logic        memReqValid;
  logic        memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [31:0] expAddr;
  int reqCount;
  logic [7:0] stallCnt;

  always #5 clk = ~clk;

  cxc_top uut (.*);

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[7:0], a[31:8]} ^ 32'h5A5A_A5A5;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // card memory model: stalls one cycle in three, responds one cycle after accept
  always @(negedge clk) begin
    stallCnt    = stallCnt + 8'd1;
    memReqReady = (stallCnt % 3) != 0;
  end

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      check(memReqAddr == expAddr, "R4 request address", memReqAddr, expAddr);
      expAddr = expAddr + 32'd4;
      reqCount++;
      memRspValid <= 1'b1;
      memRspData  <= memWord(memReqAddr);
    end
  end

  task automatic writeHalf(input logic [1:0] idx, input logic [15:0] v);
    cmdWrEn = 1'b1; cmdWrIdx = idx; cmdWrHalf = v;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  // R1: halfword k = {byte 2k+1, byte 2k}; written in reverse index order
  task automatic loadCmd(input logic [7:0] op, input logic [31:0] a);
    writeHalf(2'd3, 16'h0000);
    writeHalf(2'd2, {8'h00, a[7:0]});
    writeHalf(2'd1, {a[15:8], a[23:16]});
    writeHalf(2'd0, {a[31:24], op});
  endtask

  task automatic writeCtrl(input bit start, input logic [2:0] code);
    ctrlWrEn = 1'b1; ctrlWrData = {start, 4'b0000, code};
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic runRead(input logic [2:0] code, input logic [31:0] base, input bit poke);
    int words;
    logic [31:0] saved;
    words = (code == 3'd0) ? 0 : (code == 3'd7) ? 1 : (64 << code);
    loadCmd(8'hB7, base);
    expAddr  = base;
    reqCount = 0;
    writeCtrl(1'b1, code);
    check(statusCtrl[7] == 1'b1, "R10 busy after start", {24'h0, statusCtrl}, 32'h80);
    for (int k = 0; k < words; k++) begin
      while (!statusCtrl[6]) @(negedge clk);
      check(dataRdData == memWord(base + 32'(4 * k)), "R5 R2 word data", dataRdData, memWord(base + 32'(4 * k)));
      if (k == 0 && poke) begin
        writeCtrl(1'b1, code + 3'd1);
        check(statusCtrl[2:0] == code, "R11 write while busy", {29'h0, statusCtrl[2:0]}, {29'h0, code});
      end
      dataRdEn = 1'b1;
      @(negedge clk);
      dataRdEn = 1'b0;
      check(statusCtrl[6] == 1'b0, "R6 ready cleared by read", {31'h0, statusCtrl[6]}, 32'h0);
      if (k < words - 1) begin
        saved    = dataRdData;
        dataRdEn = 1'b1;
        @(negedge clk);
        dataRdEn = 1'b0;
        check(!statusCtrl[6] && dataRdData == saved, "R7 stale read", dataRdData, saved);
      end
    end
    while (statusCtrl[7]) @(negedge clk);
    check(dataRdData == 32'h0, "R8 buffer cleared", dataRdData, 32'h0);
    check(statusCtrl[6] == 1'b0, "R8 ready cleared", {31'h0, statusCtrl[6]}, 32'h0);
    check(reqCount == words, "R3 word count", 32'(reqCount), 32'(words));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    stallCnt = 8'd0; memReqReady = 1'b0;
    memRspValid = 1'b0; memRspData = 32'h0;
    expAddr = 32'h0; reqCount = 0;
    rstN = 1'b0; cmdWrEn = 1'b0; cmdWrIdx = 2'd0; cmdWrHalf = 16'h0;
    ctrlWrEn = 1'b0; ctrlWrData = 8'h0; dataRdEn = 1'b0;
    repeat (3) @(negedge clk);
    check(statusCtrl == 8'h00, "R12 reset status", {24'h0, statusCtrl}, 32'h0);
    check(dataRdData == 32'h0, "R12 reset data", dataRdData, 32'h0);
    check(memReqValid == 1'b0, "R12 reset request", {31'h0, memReqValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R10: size-only write
    writeCtrl(1'b0, 3'd5);
    repeat (4) @(negedge clk);
    check(statusCtrl == 8'h05, "R10 size-only write", {24'h0, statusCtrl}, 32'h05);
    check(reqCount == 0, "R10 no request", 32'(reqCount), 32'h0);

    // R9: unknown opcode
    loadCmd(8'h12, 32'h0000_1000);
    reqCount = 0;
    writeCtrl(1'b1, 3'd3);
    repeat (6) @(negedge clk);
    check(statusCtrl[7] == 1'b0, "R9 not busy", {24'h0, statusCtrl}, 32'h03);
    check(reqCount == 0, "R9 no request", 32'(reqCount), 32'h0);

    // R1 R2 R11: byte order plus write while busy
    runRead(3'd1, 32'hA1B2_C3D4, 1'b1);

    // R3: sweep every size code
    for (int c = 0; c < 8; c++) begin
      runRead(3'(c), 32'h0ABC_0000 ^ {4'(c), 28'h0010_F00}, 1'b0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule